// File: doc/BRIEF.md
# GPIO Pad Controller with Level Interrupts

This block holds the per-pin pad settings for a 24-pin bank and returns the sampled pad levels. Software reaches it over a plain 32-bit register bus made of a word address, a write strobe, write data and combinational read data. Most registers keep one bit per pin, and bit n belongs to pin n. Those bits drive the pad controls straight out of the block: output value, output enable, input enable, pull, a 2-bit drive strength, slew rate and input type. One more register is a function-select bitmap that goes to the pin-function multiplexers outside the block.

Pad inputs pass through a two-flop synchronizer. Its output feeds the read-only input level register and the interrupt gating. The upper eight pins, 16 to 23, each drive a dedicated level-sensitive interrupt line with its own mask bit. No status is latched, so a line drops as soon as its condition goes away.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every register reads zero, every pad control output is zero and every interrupt line is low.
- R2: A write to a writable register is visible on the following read and on the matching pad output in the cycle after the write edge. Word offsets: 0x00 function map (func_sel_o), 0x04 input enable (pad_ie_o), 0x08 interrupt mask, 0x0C input type (pad_itype_o), 0x10 output value (pad_out_o), 0x14 output enable (pad_oe_o), 0x1C pull enable, 0x20 pull select, 0x24 slew rate (pad_slew_o), 0x28 drive bit 0, 0x2C drive bit 1. Address bits 1:0 are ignored.
- R3: Register bits 31:24 always read zero, and writing them has no effect.
- R4: The input level register at 0x18 returns pad_in_i delayed by exactly two clock edges. Writes to 0x18 are ignored. Reading the output value register returns the written value, whatever the pad level.
- R5: The function-select register is a bitmap. Each bit is set or cleared by its own write and shows on func_sel_o at the same position.
- R6: Pull decode for pin n: pad_pu_o[n] = pull enable & pull select, and pad_pd_o[n] = pull enable & ~pull select. With pull enable clear, the pin has no pull.
- R7: pad_drv_o[2n+1:2n] = {drive bit 1[n], drive bit 0[n]} for each pin n.
- R8: irq_o[k] is high exactly when mask bit k, input enable bit 16+k and the synchronized level of pin 16+k are all set. It falls two edges after the pad level falls, and no state is latched.
- R9: Offsets 0x30 to 0x3C read zero, and writes to them change no register.
- R10: Pins 0 to 15 never affect the interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pad_in_i | input | 24 | Raw pad input levels |
| pad_out_o | output | 24 | Output value per pin |
| pad_oe_o | output | 24 | Output enable per pin |
| pad_ie_o | output | 24 | Input enable per pin |
| pad_pu_o | output | 24 | Pull-up active per pin |
| pad_pd_o | output | 24 | Pull-down active per pin |
| pad_drv_o | output | 48 | 2-bit drive strength per pin |
| pad_slew_o | output | 24 | Slew rate per pin |
| pad_itype_o | output | 24 | Input type per pin |
| func_sel_o | output | 24 | Function-select bitmap |
| irq_o | output | 8 | Level interrupts for pins 16 to 23 |

## Verification
The bench times the input path by checking the input level register one edge after a pad change, when it must still hold the old value, and again at the second edge. A synchronizer with one flop too few or too many fails one of those two reads. Interrupts are driven through all three gating terms, a falling pad and pins 0 to 15. A line that latched, ignored the input enable or took the wrong pin stays high or picks up a low pin. Writes to the level register, to the top byte and to the unmapped offsets are followed by read-back of every register, so a stray write decode shows up as a corrupted neighbour. The drive and pull outputs are compared bit by bit, which catches swapped drive planes and an inverted pull select.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int unsigned IDX_FUNC  = 0;
  localparam int unsigned IDX_IE    = 1;
  localparam int unsigned IDX_IMASK = 2;
  localparam int unsigned IDX_ITYPE = 3;
  localparam int unsigned IDX_OUT   = 4;
  localparam int unsigned IDX_OE    = 5;
  localparam int unsigned IDX_LVL   = 6;
  localparam int unsigned IDX_PE    = 7;
  localparam int unsigned IDX_PS    = 8;
  localparam int unsigned IDX_SLEW  = 9;
  localparam int unsigned IDX_DRV0  = 10;
  localparam int unsigned IDX_DRV1  = 11;
  localparam int unsigned NUM_REGS  = 12;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pad_pkg::*;
#(
  parameter int unsigned N  = 24,
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [AW-1:0]                addr_i,
  input  logic                         we_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic [N-1:0]                 level_i,
  output logic [NUM_REGS-1:0][N-1:0]   cfg_o,
  output logic [DW-1:0]                rdata_o
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  assign idx = addr_i[AW-1:2];

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:N]};

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == IDX_LVL) begin : g_ro
      assign cfg_o[r] = '0;
    end else begin : g_rw
      logic [N-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && idx == IW'(r)) q <= wdata_i[N-1:0];
      end
      assign cfg_o[r] = q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx == IW'(IDX_LVL))           rdata_o[N-1:0] = level_i;
    else if (idx < IW'(NUM_REGS))      rdata_o[N-1:0] = cfg_o[idx];
  end
endmodule

// File: rtl/gpio_irq_gate.sv
module gpio_irq_gate #(
  parameter int unsigned N    = 24,
  parameter int unsigned BASE = 16,
  parameter int unsigned NIRQ = 8
) (
  input  logic [N-1:0]    mask_i,
  input  logic [N-1:0]    ie_i,
  input  logic [N-1:0]    lvl_i,
  output logic [NIRQ-1:0] irq_o
);
  logic unused_rest;
  assign unused_rest = ^{mask_i[N-1:NIRQ], ie_i[BASE-1:0], lvl_i[BASE-1:0]};

  for (genvar k = 0; k < NIRQ; k++) begin : g_line
    assign irq_o[k] = mask_i[k] & ie_i[BASE+k] & lvl_i[BASE+k];
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int unsigned N    = 24,
  parameter int unsigned AW   = 6,
  parameter int unsigned DW   = 32,
  parameter int unsigned BASE = 16,
  parameter int unsigned NIRQ = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [N-1:0]    pad_in_i,
  output logic [N-1:0]    pad_out_o,
  output logic [N-1:0]    pad_oe_o,
  output logic [N-1:0]    pad_ie_o,
  output logic [N-1:0]    pad_pu_o,
  output logic [N-1:0]    pad_pd_o,
  output logic [2*N-1:0]  pad_drv_o,
  output logic [N-1:0]    pad_slew_o,
  output logic [N-1:0]    pad_itype_o,
  output logic [N-1:0]    func_sel_o,
  output logic [NIRQ-1:0] irq_o
);
  logic [N-1:0] lvl_sync;
  logic [NUM_REGS-1:0][N-1:0] cfg;

  gpio_sync #(.W(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (lvl_sync)
  );

  gpio_regfile #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .level_i(lvl_sync),
    .cfg_o  (cfg),
    .rdata_o(rdata_o)
  );

  gpio_irq_gate #(.N(N), .BASE(BASE), .NIRQ(NIRQ)) u_irq (
    .mask_i(cfg[IDX_IMASK]),
    .ie_i  (cfg[IDX_IE]),
    .lvl_i (lvl_sync),
    .irq_o (irq_o)
  );

  logic unused_lvl;
  assign unused_lvl = ^cfg[IDX_LVL];

  assign func_sel_o  = cfg[IDX_FUNC];
  assign pad_out_o   = cfg[IDX_OUT];
  assign pad_oe_o    = cfg[IDX_OE];
  assign pad_ie_o    = cfg[IDX_IE];
  assign pad_slew_o  = cfg[IDX_SLEW];
  assign pad_itype_o = cfg[IDX_ITYPE];
  assign pad_pu_o    = cfg[IDX_PE] & cfg[IDX_PS];
  assign pad_pd_o    = cfg[IDX_PE] & ~cfg[IDX_PS];

  for (genvar n = 0; n < N; n++) begin : g_drv
    assign pad_drv_o[2*n+1:2*n] = {cfg[IDX_DRV1][n], cfg[IDX_DRV0][n]};
  end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk
  import gpio_pad_pkg::*;
#(
  parameter int unsigned N    = 24,
  parameter int unsigned AW   = 6,
  parameter int unsigned DW   = 32,
  parameter int unsigned BASE = 16,
  parameter int unsigned NIRQ = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   addr_i,
  input logic            we_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic [N-1:0]    pad_in_i,
  input logic [N-1:0]    pad_oe_o,
  input logic [N-1:0]    pad_ie_o,
  input logic [N-1:0]    lvl_sync,
  input logic [NIRQ-1:0] irq_o
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  a_r2_oe_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[AW-1:2] == (AW-2)'(IDX_OE)) |=> pad_oe_o == $past(wdata_i[N-1:0]));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o >> N) == '0);

  a_r4_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> lvl_sync == $past(pad_in_i, 2));

  a_r8_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~pad_ie_o[BASE+:NIRQ]) == '0);

  a_r8_irq_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~lvl_sync[BASE+:NIRQ]) == '0);
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(
  .N(N), .AW(AW), .DW(DW), .BASE(BASE), .NIRQ(NIRQ)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_in_i(pad_in_i),
  .pad_oe_o(pad_oe_o),
  .pad_ie_o(pad_ie_o),
  .lvl_sync(lvl_sync),
  .irq_o   (irq_o)
);

// File: tb/gpio_pad_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_tb;
  localparam int N = 24;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [5:0]  addr_i = '0;
  logic        we_i = 0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N-1:0] pad_in_i = '0;
  logic [N-1:0] pad_out_o, pad_oe_o, pad_ie_o, pad_pu_o, pad_pd_o;
  logic [2*N-1:0] pad_drv_o;
  logic [N-1:0] pad_slew_o, pad_itype_o, func_sel_o;
  logic [7:0]  irq_o;

  gpio_pad_ctrl u_dut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] m [12];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk_i);
    addr_i = 6'(idx << 2); we_i = 1; wdata_i = d;
    @(negedge clk_i);
    we_i = 0;
    if (idx < 12 && idx != 6) m[idx] = d[N-1:0];
  endtask

  function automatic logic [31:0] exp_rd(int idx);
    if (idx == 6) return {8'h0, pad_in_i};
    if (idx < 12) return {8'h0, m[idx]};
    return 32'h0;
  endfunction

  function automatic logic [2*N-1:0] exp_drv();
    logic [2*N-1:0] v;
    for (int n = 0; n < N; n++) v[2*n+:2] = {m[11][n], m[10][n]};
    return v;
  endfunction

  function automatic logic [7:0] exp_irq();
    return m[2][7:0] & m[1][23:16] & pad_in_i[23:16];
  endfunction

  task automatic rd(string tag, int idx);
    addr_i = 6'(idx << 2); #1;
    chk(tag, 64'(rdata_o), 64'(exp_rd(idx)));
  endtask

  task automatic pads(string tag);
    chk({tag, " out"}, 64'(pad_out_o), 64'(m[4]));
    chk({tag, " oe"}, 64'(pad_oe_o), 64'(m[5]));
    chk({tag, " ie"}, 64'(pad_ie_o), 64'(m[1]));
    chk({tag, " pu"}, 64'(pad_pu_o), 64'(m[7] & m[8]));
    chk({tag, " pd"}, 64'(pad_pd_o), 64'(m[7] & ~m[8]));
    chk({tag, " drv"}, 64'(pad_drv_o), 64'(exp_drv()));
    chk({tag, " slew"}, 64'(pad_slew_o), 64'(m[9]));
    chk({tag, " itype"}, 64'(pad_itype_o), 64'(m[3]));
    chk({tag, " func"}, 64'(func_sel_o), 64'(m[0]));
    chk({tag, " irq"}, 64'(irq_o), 64'(exp_irq()));
  endtask

  task automatic settle(); repeat (3) @(negedge clk_i); #1; endtask

  initial begin
    for (int i = 0; i < 12; i++) m[i] = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R1 reset state
    for (int i = 0; i < 16; i++) rd("R1 reset read", i);
    pads("R1 reset pads");

    // R2 each writable register reaches its pad output
    for (int i = 0; i < 12; i++) if (i != 6) begin
      wr(i, 32'h00A5_5A3C ^ (i * 32'h0001_1111));
      #1; rd("R2 readback", i); pads("R2 pads");
    end

    // R3 top byte ignored
    wr(4, 32'hFFFF_FFFF); #1;
    chk("R3 upper bits", 64'(rdata_o), 64'h00FF_FFFF);

    // R4 two-edge latency, read-only level, output value independent of pad
    @(negedge clk_i); pad_in_i = 24'h5A_C3F0; addr_i = 6'h18;
    @(negedge clk_i); #1;
    chk("R4 level after one edge", 64'(rdata_o), 64'h0);
    @(negedge clk_i); #1;
    chk("R4 level after two edges", 64'(rdata_o), 64'h5A_C3F0);
    wr(6, 32'h00FF_FFFF); #1; rd("R4 write to level ignored", 6);
    rd("R4 output value not pad", 4);

    // R5 function bitmap set/clear
    wr(0, 32'h0000_0001); wr(0, 32'h0080_0001); #1;
    chk("R5 func bits", 64'(func_sel_o), 64'h80_0001);
    wr(0, 32'h0080_0000); #1;
    chk("R5 func clear", 64'(func_sel_o), 64'h80_0000);

    // R6 pull codes
    wr(7, 32'h0000_0006); wr(8, 32'h0000_0004); #1;
    chk("R6 pull-up", 64'(pad_pu_o), 64'h4);
    chk("R6 pull-down", 64'(pad_pd_o), 64'h2);
    wr(7, 32'h0); #1;
    chk("R6 no pull", 64'(pad_pu_o | pad_pd_o), 64'h0);

    // R7 drive planes
    wr(10, 32'h0000_0001); wr(11, 32'h0000_0003); #1;
    chk("R7 drive planes", 64'(pad_drv_o[5:0]), 64'b00_1011);

    // R8 interrupt gating and no latch
    wr(1, 32'h00FF_0000); wr(2, 32'h0000_00FF);
    @(negedge clk_i); pad_in_i = 24'h81_0000; settle();
    chk("R8 irq on", 64'(irq_o), 64'h81);
    @(negedge clk_i); pad_in_i = 24'h01_0000; settle();
    chk("R8 irq drops with level", 64'(irq_o), 64'h01);
    wr(2, 32'h0000_00FE); #1;
    chk("R8 irq masked", 64'(irq_o), 64'h00);
    wr(2, 32'h0000_00FF); wr(1, 32'h00FE_0000); #1;
    chk("R8 irq needs input enable", 64'(irq_o), 64'h00);

    // R10 low pins never interrupt
    wr(1, 32'h00FF_FFFF);
    @(negedge clk_i); pad_in_i = 24'h00_FFFF; settle();
    chk("R10 low pins no irq", 64'(irq_o), 64'h00);

    // R9 unmapped offsets
    for (int i = 12; i < 16; i++) wr(i, 32'hFFFF_FFFF);
    #1;
    for (int i = 0; i < 16; i++) rd("R9 after unmapped writes", i);

    // random mix, R2 R4 R8
    for (int it = 0; it < 200; it++) begin
      int idx;
      idx = int'($urandom % 16);
      @(negedge clk_i); pad_in_i = N'($urandom);
      wr(idx, $urandom);
      settle();
      rd("R2 random read", int'($urandom % 16));
      pads("R8 random pads");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule